// File: doc/BRIEF.md
# Divided Countdown Timer with Expiry Backlog

This block is the timer portion of a local interrupt unit. Software programs a start value, a clock divider and a timer vector entry through a simple 32-bit register port. The block counts bus-clock cycles through a power-of-two prescaler and decrements a current count on each divided tick. When the count runs out, the timer either stops at zero (one-shot) or reloads the start value (periodic).

Each expiry is added to a saturating backlog counter. The block does not drop expiries that the interrupt tracker cannot take at once. While the timer entry is unmasked and the backlog is non-zero, it raises an injection request that carries the entry's vector, in fixed delivery and edge trigger. The backlog drops by one only in a cycle where that request is accepted. A software-enable bit in a control register acts as a global kill switch. Clearing it masks every vector entry and drops the backlog.

Register indices on `wr_addr`/`rd_addr`: 0..5 vector entries (0 is the timer entry), 6 control (spurious-vector) register, 7 start value, 8 current count, 9 divide configuration, anything else unmapped.

Top module: `divcount_timer`

## Requirements
- R1: The divide register keeps only bits 3, 1 and 0 and reads 0 elsewhere. The code {bit3,bit1,bit0} gives a ratio of 2^((code+1) mod 8), so code 7 counts every cycle and codes 0..6 count every 2..128 cycles.
- R2: Writing index 7 with N loads both the start value and the current count with N and restarts the prescaler. With ratio R, the first expiry lands on the N*R-th rising edge after the write edge.
- R3: Writing the start value clears the expiry backlog. The request is low in the cycle after such a write.
- R4: Index 8 reads the current count. In one-shot mode (timer entry bit 17 = 0) it stops at 0 after expiry. In periodic mode (bit 17 = 1) it reloads the start value at each expiry.
- R5: Each expiry adds one to the backlog. `inj_req` is high exactly when timer entry bit 16 (mask) is 0 and the backlog is non-zero, with `inj_vector` equal to entry bits 7:0. The backlog drops by one only on a clock where `inj_req` and `inj_ack` are both high, so an acknowledge while masked has no effect.
- R6: The backlog holds 2^PEND_W-1 as its largest value and does not wrap when further expiries arrive.
- R7: The control register keeps bits 9:0, and bit 8 is the software enable. Writing it with bit 8 = 0 sets bit 16 in all six entries and clears the backlog. While bit 8 is 0, every entry write is stored with bit 16 forced to 1.
- R8: A vector entry stores only bits 7:0 (vector), 12 (delivery status), 16 (mask) and 17 (periodic); all other bits read 0.
- R9: After reset every entry reads 0x00010000, the control register reads 0x000000FF, and the start value, current count and divide register read 0.
- R10: A start value of 0 leaves the timer stopped: the current count stays 0 and no expiry occurs.
- R11: Writes to the current-count index are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; also the timer's count source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register index for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Register index for reads |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| inj_req | output | 1 | Timer injection request (fixed delivery, edge trigger) |
| inj_vector | output | 8 | Vector carried by the request |
| inj_ack | input | 1 | Tracker accepts the request in this cycle |

## Verification
The backlog has no read port, so a wrong backlog value only shows up at the request pin. A count that is too small drops the request early while acknowledges are held. A count that is too large, or that wrapped, keeps the request high for the wrong number of accepted cycles. Either error can show up many cycles after its cause, at the end of a drain. A wrong prescaler or reload shows sooner: the current-count read and the first rise of the request move by whole divided periods. The bench compares the request, vector and selected register against a behavioural model on every clock, so such a shift is caught within one cycle of its first effect.

// File: rtl/divcount_timer.sv
`timescale 1ns/1ps
module divcount_timer #(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 4,
  parameter int N_ENT  = 6,
  parameter int AW     = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic          inj_req,
  output logic [7:0]    inj_vector,
  input  logic          inj_ack
);
  localparam int A_SVR  = N_ENT;
  localparam int A_INIT = N_ENT + 1;
  localparam int A_CUR  = N_ENT + 2;
  localparam int A_DIV  = N_ENT + 3;
  localparam int MASK_B = 16;
  localparam int PER_B  = 17;
  localparam int SWEN_B = 8;
  localparam logic [31:0] ENT_KEEP = 32'h0003_10FF;
  localparam logic [31:0] MASK_V   = 32'h1 << MASK_B;
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [31:0]       ent [N_ENT];
  logic [9:0]        svr;
  logic [2:0]        div_q;
  logic [CNT_W-1:0]  init_q, cur;
  logic [6:0]        presc;
  logic [PEND_W-1:0] pend;

  wire       wr_init  = wr_en && (wr_addr == AW'(A_INIT));
  wire       wr_svr   = wr_en && (wr_addr == AW'(A_SVR));
  wire       wr_div   = wr_en && (wr_addr == AW'(A_DIV));
  wire       sw_off   = wr_svr && !wr_data[SWEN_B];
  wire       sw_en    = svr[SWEN_B];
  wire [2:0] shift    = div_q + 3'd1;
  wire [7:0] ratio    = 8'd1 << shift;
  wire [6:0] last     = 7'(ratio - 8'd1);
  wire       running  = (cur != '0);
  wire       tick     = running && (presc >= last);
  wire       expire   = tick && (cur == CNT_W'(1));
  wire       tmr_mask = ent[0][MASK_B];
  wire       accept   = inj_req && inj_ack;

  assign inj_req    = !tmr_mask && (pend != '0);
  assign inj_vector = ent[0][7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) ent[i] <= MASK_V;
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (sw_off)
          ent[i] <= ent[i] | MASK_V;
        else if (wr_en && (wr_addr == AW'(i)))
          ent[i] <= (wr_data & ENT_KEEP) | (sw_en ? 32'd0 : MASK_V);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svr   <= 10'h0FF;
      div_q <= '0;
    end else begin
      if (wr_svr) svr <= wr_data[9:0];
      if (wr_div) div_q <= {wr_data[3], wr_data[1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0;
      cur    <= '0;
      presc  <= '0;
    end else if (wr_init) begin
      init_q <= wr_data[CNT_W-1:0];
      cur    <= wr_data[CNT_W-1:0];
      presc  <= '0;
    end else if (!running) begin
      presc <= '0;
    end else if (tick) begin
      presc <= '0;
      if (expire) cur <= ent[0][PER_B] ? init_q : '0;
      else        cur <= cur - CNT_W'(1);
    end else begin
      presc <= presc + 7'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend <= '0;
    else if (wr_init || sw_off)
      pend <= '0;
    else if (expire && !accept) begin
      if (pend != PEND_MAX) pend <= pend + 1'b1;
    end else if (accept && !expire)
      pend <= pend - 1'b1;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_ENT; i++)
      if (rd_addr == AW'(i)) rd_data = ent[i];
    if (rd_addr == AW'(A_SVR))  rd_data = {22'd0, svr};
    if (rd_addr == AW'(A_INIT)) rd_data = 32'(init_q);
    if (rd_addr == AW'(A_CUR))  rd_data = 32'(cur);
    if (rd_addr == AW'(A_DIV))  rd_data = {28'd0, div_q[2], 1'b0, div_q[1:0]};
  end
endmodule

module divcount_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 4,
  parameter int N_ENT  = 6,
  parameter int AW     = 4
)(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [31:0]       wr_data,
  input logic              inj_req,
  input logic              inj_ack,
  input logic              expire,
  input logic              tmr_mask,
  input logic [CNT_W-1:0]  cur,
  input logic [PEND_W-1:0] pend
);
  wire w_init = wr_en && (wr_addr == AW'(N_ENT + 1));
  wire w_off  = wr_en && (wr_addr == AW'(N_ENT)) && !wr_data[8];
  wire acc    = inj_req && inj_ack;

  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    w_init |=> cur == $past(wr_data[CNT_W-1:0])); // R2
  AST_INIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    w_init |=> pend == '0); // R3
  AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == '0 && !w_init) |=> cur == '0); // R4
  AST_ACCEPT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !expire && !w_init && !w_off) |=> pend == $past(pend) - 1'b1); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '1 && expire && !acc && !w_init && !w_off) |=> pend == '1); // R6
  AST_DISABLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    w_off |=> (tmr_mask && pend == '0)); // R7
endmodule

bind divcount_timer divcount_timer_chk #(
  .CNT_W(CNT_W), .PEND_W(PEND_W), .N_ENT(N_ENT), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .inj_req(inj_req), .inj_ack(inj_ack), .expire(expire), .tmr_mask(tmr_mask),
  .cur(cur), .pend(pend)
);

// File: tb/divcount_timer_test.sv
`timescale 1ns/1ps
module divcount_timer_test;
  localparam int CLK_P = 10;
  localparam int A_SVR = 6, A_INIT = 7, A_CUR = 8, A_DIV = 9;
  localparam int PMAX = 15;

  logic        clk = 0, rst_n = 0, wr_en = 0, inj_ack = 0;
  logic [3:0]  wr_addr = 0, rd_addr = 4'(A_CUR);
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        inj_req;
  logic [7:0]  inj_vector;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  divcount_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .inj_req(inj_req), .inj_vector(inj_vector),
    .inj_ack(inj_ack)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_ent [6];
  logic [31:0] m_svr, m_div, m_init, m_cur;
  int m_presc, m_pend;

  always @(posedge clk) begin
    int code, ratio;
    bit per, acc, ex;
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) m_ent[i] = 32'h0001_0000;
      m_svr = 32'hFF; m_div = 0; m_init = 0; m_cur = 0; m_presc = 0; m_pend = 0;
    end else begin
      code  = {m_div[3], m_div[1], m_div[0]};
      ratio = 1 << ((code + 1) % 8);
      per   = m_ent[0][17];
      acc   = inj_ack && !m_ent[0][16] && m_pend > 0;
      ex    = 0;
      if (wr_en && wr_addr == 4'(A_INIT)) begin
        m_init = wr_data; m_cur = wr_data; m_presc = 0; m_pend = 0;
      end else begin
        if (m_cur == 0) m_presc = 0;
        else if (m_presc >= ratio - 1) begin
          m_presc = 0;
          if (m_cur == 1) begin ex = 1; m_cur = per ? m_init : 0; end
          else m_cur = m_cur - 1;
        end else m_presc++;
        if (wr_en && wr_addr == 4'(A_SVR) && !wr_data[8]) m_pend = 0;
        else begin
          m_pend = m_pend + int'(ex) - int'(acc);
          if (m_pend > PMAX) m_pend = PMAX;
        end
      end
      if (wr_en && wr_addr < 6)
        m_ent[wr_addr] = (wr_data & 32'h0003_10FF) | (m_svr[8] ? 32'd0 : 32'h0001_0000);
      if (wr_en && wr_addr == 4'(A_SVR)) begin
        m_svr = wr_data & 32'h3FF;
        if (!wr_data[8]) for (int i = 0; i < 6; i++) m_ent[i] = m_ent[i] | 32'h0001_0000;
      end
      if (wr_en && wr_addr == 4'(A_DIV)) m_div = wr_data & 32'hB;
    end
  end

  function automatic logic [31:0] mrd(input logic [3:0] a);
    if (a < 6) return m_ent[a];
    case (a)
      4'(A_SVR):  return m_svr;
      4'(A_INIT): return m_init;
      4'(A_CUR):  return m_cur;
      4'(A_DIV):  return m_div;
      default:    return 0;
    endcase
  endfunction

  function automatic string rtag(input logic [3:0] a);
    if (a < 6) return "R8";
    case (a)
      4'(A_SVR):  return "R7";
      4'(A_INIT): return "R2";
      4'(A_CUR):  return "R4";
      4'(A_DIV):  return "R1";
      default:    return "R11";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      #2;
      check("R5 req", {31'd0, inj_req}, {31'd0, (!m_ent[0][16] && m_pend > 0)});
      if (inj_req) check("R5 vector", {24'd0, inj_vector}, {24'd0, m_ent[0][7:0]});
      check(rtag(rd_addr), rd_data, mrd(rd_addr));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1; wr_addr = 4'(a); wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    rd_addr = 4'(a); #1; v = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!inj_req && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic drain(output int n);
    n = 0; inj_ack = 1;
    while (inj_req && n < 100) begin @(negedge clk); n++; end
    inj_ack = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    int dv[5] = '{32'h0B, 32'hF4, 32'h02, 32'h0A, 32'h03};
    int nv[5] = '{5, 3, 4, 2, 3};
    int ev[5] = '{5, 6, 32, 256, 48};
    idle(3); rst_n = 1; @(negedge clk);

    // R9 reset state
    rd(0, v); check("R9 entry0", v, 32'h0001_0000);
    rd(3, v); check("R9 entry3", v, 32'h0001_0000);
    rd(A_SVR, v); check("R9 ctrl", v, 32'hFF);
    rd(A_INIT, v); check("R9 start", v, 0);
    rd(A_DIV, v); check("R9 div", v, 0);
    check("R9 req", {31'd0, inj_req}, 0);
    rd_addr = 4'(A_CUR);

    wr(A_SVR, 32'h1FF);
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); check("R8 kept bits", v, 32'h0003_10FF);
    rd_addr = 4'(A_CUR);
    wr(0, 32'h20);

    // R1 / R2 divide ratios and expiry timing
    for (int k = 0; k < 5; k++) begin
      wr(A_DIV, dv[k]);
      rd(A_DIV, v); check("R1 div readback", v, dv[k] & 32'hB);
      rd_addr = 4'(A_CUR);
      @(negedge clk);
      wr(A_INIT, nv[k]);
      wait_req(n);
      check("R1 R2 expiry delay", n, ev[k]);
      check("R5 vector", {24'd0, inj_vector}, 32'h20);
      drain(n); check("R5 single expiry", n, 1);
      rd(A_CUR, v); check("R4 one-shot stop", v, 0);
    end

    // R5 acknowledge while masked does nothing
    wr(A_DIV, 32'h0B);
    wr(0, 32'h0003_0020);
    wr(A_INIT, 4);
    idle(9);
    wr(0, 32'h0001_0020);
    inj_ack = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R5 masked no req", {31'd0, inj_req}, 0);
    end
    inj_ack = 0;
    wr(0, 32'h20);
    drain(n); check("R5 backlog kept while masked", n, 3);

    // R6 saturation
    wr(0, 32'h0002_0020);
    wr(A_INIT, 3);
    idle(60);
    wr(0, 32'h20);
    idle(6);
    rd(A_CUR, v); check("R4 stopped", v, 0);
    drain(n); check("R6 saturated backlog", n, PMAX);

    // R3 / R10
    wr(0, 32'h0002_0020);
    wr(A_INIT, 2);
    idle(5);
    check("R3 pending before", {31'd0, inj_req}, 1);
    wr(A_INIT, 0);
    check("R3 cleared", {31'd0, inj_req}, 0);
    idle(20);
    check("R10 no expiry", {31'd0, inj_req}, 0);
    rd(A_CUR, v); check("R10 count idle", v, 0);

    // R11
    wr(A_CUR, 32'h1234);
    rd(A_CUR, v); check("R11 write ignored", v, 0);

    // R7 software disable
    wr(A_INIT, 2);
    idle(5);
    wr(A_SVR, 32'h0FF);
    check("R7 req dropped", {31'd0, inj_req}, 0);
    for (int i = 0; i < 6; i++) begin
      rd(i, v); check("R7 entry masked", {31'd0, v[16]}, 1);
    end
    wr(0, 32'h20);
    rd(0, v); check("R7 forced mask", v, 32'h0001_0020);
    wr(A_SVR, 32'h1FF);
    rd(0, v); check("R7 mask persists", v, 32'h0001_0020);
    rd_addr = 4'(A_CUR);
    wr(0, 32'h20);
    idle(10);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule